// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired controller for a multicycle processor datapath that shares one memory and one ALU across the steps of an instruction. A 4-bit state register walks through ten states. Every datapath control it drives depends on the current state alone, so it is a Moore machine. The 6-bit opcode field of the instruction register is looked at in two places. In the decode step it picks the execute path. In the memory-address step it chooses between the load path and the store path.

An instruction takes 3, 4 or 5 cycles, depending on its class. During decode the ALU computes the branch target before the opcode is known, so a taken branch can complete one cycle later. An opcode outside the supported set does not stall the machine. The controller returns to fetch and raises a one-cycle illegal-instruction flag, which the surrounding core can act on. Control outputs with no defined value in a state are driven low.

Top module: `mcc_ctrl_top`

## Requirements
- R1: While `rst_n` is low, and until the internal reset release has passed through the synchronizer, the controller holds the fetch state and `illegal_op` is 0.
- R2: Fetch drives `mem_rd`=1, `ir_wr`=1, `pc_wr`=1, `addr_sel`=0, `alu_a_sel`=0, `alu_b_sel`=01, `alu_op`=00 and `pc_src`=00. Fetch is always followed by decode.
- R3: Decode drives `alu_a_sel`=0, `alu_b_sel`=11 and `alu_op`=00 with no write strobe. The next state depends on the opcode: 000000 goes to R-type execute, 000010 goes to jump, 000100 goes to branch, and 100011 or 101011 go to address compute.
- R4: Address compute drives `alu_a_sel`=1, `alu_b_sel`=10 and `alu_op`=00. It is followed by load read when the opcode is 101011 is not present, that is, load read follows unless the opcode is 101011, in which case store write follows.
- R5: Load read drives `mem_rd`=1 and `addr_sel`=1. It is followed by write-back, which drives `rf_wr`=1, `wb_sel`=1 and `dst_sel`=0. A load (100011) takes 5 cycles from fetch to the next fetch.
- R6: Store write drives `mem_wr`=1 and `addr_sel`=1. A store (101011) takes 4 cycles.
- R7: R-type execute drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=10. It is followed by R-type completion, which drives `rf_wr`=1, `dst_sel`=1 and `wb_sel`=0. An R-type instruction takes 4 cycles.
- R8: Branch compare drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01, `pc_src`=01 and `pc_wr_cond`=1. A branch takes 3 cycles.
- R9: Jump drives `pc_src`=10 and `pc_wr`=1. A jump takes 3 cycles.
- R10: `pc_wr`, `pc_wr_cond`, `ir_wr`, `mem_wr`, `mem_rd` and `rf_wr` are 0 in every state that does not name them. Every control with no stated value is 0.
- R11: An opcode outside the five supported codes, seen in decode, sends the controller straight back to fetch. `illegal_op` is then 1 during exactly that fetch cycle and 0 in every other cycle.
- R12: The opcode has no effect in any state except decode and address compute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write qualified by the ALU zero flag |
| addr_sel | output | 1 | Memory address select: 0 program counter, 1 ALU result register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| wb_sel | output | 1 | Register write data: 0 ALU result, 1 memory data register |
| pc_src | output | 2 | Next program counter source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| alu_b_sel | output | 2 | ALU B input: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_a_sel | output | 1 | ALU A input: 0 program counter, 1 register A |
| rf_wr | output | 1 | Register file write |
| dst_sel | output | 1 | Destination register field: 0 rt, 1 rd |
| illegal_op | output | 1 | One-cycle flag for an unsupported opcode |

## Verification
The bench sweeps all 64 opcode values through complete instructions and checks the whole control vector in every cycle. A wrong dispatch entry, or a missing or stuck strobe in any state, therefore shows up as a miscompare in the cycle where it occurs. A second sweep changes the opcode during every state except decode and address compute. A controller that samples the opcode too late, or that lets it reach the output logic, would branch or strobe differently in that sweep. The bench also checks that the illegal flag appears only in the fetch cycle after an unsupported decode. A flag decoded from the wrong state, or one that stays high for two cycles, would fail that check. Finally, the bench checks that fetch outputs hold through reset and through both synchronizer stages.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int OPC_W = 6;
  localparam int ST_W  = 4;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH = 4'd0,
    ST_DEC   = 4'd1,
    ST_ADDR  = 4'd2,
    ST_LDRD  = 4'd3,
    ST_LDWB  = 4'd4,
    ST_STWR  = 4'd5,
    ST_REXE  = 4'd6,
    ST_RCMP  = 4'd7,
    ST_BEQ   = 4'd8,
    ST_JMP   = 4'd9
  } state_e;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       wb_sel;
    logic [1:0] pc_src;
    logic [1:0] alu_op;
    logic [1:0] alu_b_sel;
    logic       alu_a_sel;
    logic       rf_wr;
    logic       dst_sel;
  } ctrl_t;
endpackage

// File: rtl/mcc_rst_sync.sv
module mcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  generate
    if (STAGES < 2) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= 1'b1;
      end
      assign rst_n_sync = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= {q[STAGES-2:0], 1'b1};
      end
      assign rst_n_sync = q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
(
  input  state_e           cur,
  input  logic [OPC_W-1:0] opcode,
  output state_e           nxt,
  output logic             bad_op
);
  always_comb begin
    nxt    = ST_FETCH;
    bad_op = 1'b0;
    unique case (cur)
      ST_FETCH: nxt = ST_DEC;
      ST_DEC: begin
        unique case (opcode)
          OPC_RTYPE:           nxt = ST_REXE;
          OPC_JUMP:            nxt = ST_JMP;
          OPC_BEQ:             nxt = ST_BEQ;
          OPC_LOAD, OPC_STORE: nxt = ST_ADDR;
          default: begin
            nxt    = ST_FETCH;
            bad_op = 1'b1;
          end
        endcase
      end
      ST_ADDR: nxt = (opcode == OPC_STORE) ? ST_STWR : ST_LDRD;
      ST_LDRD: nxt = ST_LDWB;
      ST_REXE: nxt = ST_RCMP;
      default: nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
  import mcc_pkg::*;
(
  input  state_e cur,
  output ctrl_t  ctl
);
  always_comb begin
    ctl = '0;
    unique case (cur)
      ST_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_wr     = 1'b1;
        ctl.pc_wr     = 1'b1;
        ctl.alu_b_sel = 2'b01;
      end
      ST_DEC:  ctl.alu_b_sel = 2'b11;
      ST_ADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = 2'b10;
      end
      ST_LDRD: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctl.rf_wr  = 1'b1;
        ctl.wb_sel = 1'b1;
      end
      ST_STWR: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_REXE: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_op    = 2'b10;
      end
      ST_RCMP: begin
        ctl.rf_wr   = 1'b1;
        ctl.dst_sel = 1'b1;
      end
      ST_BEQ: begin
        ctl.alu_a_sel  = 1'b1;
        ctl.alu_op     = 2'b01;
        ctl.pc_src     = 2'b01;
        ctl.pc_wr_cond = 1'b1;
      end
      ST_JMP: begin
        ctl.pc_src = 2'b10;
        ctl.pc_wr  = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mcc_ctrl_top.sv
module mcc_ctrl_top
  import mcc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output logic             pc_wr,
  output logic             pc_wr_cond,
  output logic             addr_sel,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ir_wr,
  output logic             wb_sel,
  output logic [1:0]       pc_src,
  output logic [1:0]       alu_op,
  output logic [1:0]       alu_b_sel,
  output logic             alu_a_sel,
  output logic             rf_wr,
  output logic             dst_sel,
  output logic             illegal_op
);
  logic   rst_n_s;
  state_e state_q, state_d;
  logic   bad_op;
  logic   illegal_q;
  ctrl_t  ctl;

  mcc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  mcc_next_state u_next (
    .cur    (state_q),
    .opcode (opcode),
    .nxt    (state_d),
    .bad_op (bad_op)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q   <= ST_FETCH;
      illegal_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      illegal_q <= bad_op;
    end
  end

  mcc_out_decode u_out (
    .cur (state_q),
    .ctl (ctl)
  );

  assign pc_wr      = ctl.pc_wr;
  assign pc_wr_cond = ctl.pc_wr_cond;
  assign addr_sel   = ctl.addr_sel;
  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign ir_wr      = ctl.ir_wr;
  assign wb_sel     = ctl.wb_sel;
  assign pc_src     = ctl.pc_src;
  assign alu_op     = ctl.alu_op;
  assign alu_b_sel  = ctl.alu_b_sel;
  assign alu_a_sel  = ctl.alu_a_sel;
  assign rf_wr      = ctl.rf_wr;
  assign dst_sel    = ctl.dst_sel;
  assign illegal_op = illegal_q;

  AST_RESET_FETCH: assert property (@(posedge clk) !rst_n_s |-> (ir_wr && !illegal_op)) // R1
    else $error("reset state is not fetch");
  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_FETCH) |=> (state_q == ST_DEC)) // R2
    else $error("fetch not followed by decode");
  AST_DECODE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (alu_b_sel == 2'b11) |-> !(pc_wr || pc_wr_cond || mem_wr || rf_wr || ir_wr)) // R3
    else $error("write strobe during decode");
  AST_LOAD_CHAIN: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_LDRD) |=> (rf_wr && wb_sel)) // R5
    else $error("load read not followed by write-back");
  AST_RTYPE_CHAIN: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_REXE) |=> (rf_wr && dst_sel)) // R7
    else $error("R-type execute not followed by completion");
  AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n_s)
    $countones({mem_wr, rf_wr, ir_wr, pc_wr_cond}) <= 1) // R10
    else $error("more than one storage strobe");
  AST_ILLEGAL_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n_s)
    illegal_op |-> (state_q == ST_FETCH && $past(state_q) == ST_DEC)) // R11
    else $error("illegal flag outside the fetch after decode");
  AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    illegal_op |=> !illegal_op) // R11
    else $error("illegal flag longer than one cycle");
endmodule

// File: tb/mcc_ctrl_top_bench.sv
module mcc_ctrl_top_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opcode;
  logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel;
  logic [1:0] pc_src, alu_op, alu_b_sel;
  logic       alu_a_sel, rf_wr, dst_sel, illegal_op;

  int n_vec  = 0;
  int n_fail = 0;
  logic pend_ill;

  always #2.5 clk = ~clk;

  mcc_ctrl_top u_mcc_ctrl_top (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .wb_sel(wb_sel),
    .pc_src(pc_src), .alu_op(alu_op), .alu_b_sel(alu_b_sel),
    .alu_a_sel(alu_a_sel), .rf_wr(rf_wr), .dst_sel(dst_sel),
    .illegal_op(illegal_op)
  );

  // Packing: pc_wr,pc_wr_cond,addr_sel,mem_rd,mem_wr,ir_wr,wb_sel,pc_src,alu_op,alu_b_sel,alu_a_sel,rf_wr,dst_sel
  function automatic logic [16:0] pack(logic pw, logic pwc, logic as, logic mr, logic mw,
                                       logic iw, logic ws, logic [1:0] ps, logic [1:0] ao,
                                       logic [1:0] bs, logic aa, logic rw, logic ds);
    return {pw, pwc, as, mr, mw, iw, ws, ps, ao, bs, aa, rw, ds};
  endfunction

  function automatic logic [16:0] exp_ctl(int st);
    case (st)
      0: return pack(1,0,0,1,0,1,0,2'b00,2'b00,2'b01,0,0,0);
      1: return pack(0,0,0,0,0,0,0,2'b00,2'b00,2'b11,0,0,0);
      2: return pack(0,0,0,0,0,0,0,2'b00,2'b00,2'b10,1,0,0);
      3: return pack(0,0,1,1,0,0,0,2'b00,2'b00,2'b00,0,0,0);
      4: return pack(0,0,0,0,0,0,1,2'b00,2'b00,2'b00,0,1,0);
      5: return pack(0,0,1,0,1,0,0,2'b00,2'b00,2'b00,0,0,0);
      6: return pack(0,0,0,0,0,0,0,2'b00,2'b10,2'b00,1,0,0);
      7: return pack(0,0,0,0,0,0,0,2'b00,2'b00,2'b00,0,1,1);
      8: return pack(0,1,0,0,0,0,0,2'b01,2'b01,2'b00,1,0,0);
      default: return pack(1,0,0,0,0,0,0,2'b10,2'b00,2'b00,0,0,0);
    endcase
  endfunction

  function automatic string req_of(int st);
    case (st)
      0: return "R2";  1: return "R3";  2: return "R4";
      3, 4: return "R5"; 5: return "R6"; 6, 7: return "R7";
      8: return "R8";  default: return "R9";
    endcase
  endfunction

  task automatic check(int st, logic ill_exp, string tag);
    logic [16:0] act;
    act = pack(pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel,
               pc_src, alu_op, alu_b_sel, alu_a_sel, rf_wr, dst_sel);
    n_vec++;
    if (act !== exp_ctl(st) || illegal_op !== ill_exp) begin
      n_fail++;
      $display("FAIL %s (R10 strobes) state %0d: ctl=%b ill=%b expected ctl=%b ill=%b",
               tag, st, act, illegal_op, exp_ctl(st), ill_exp);
    end
  endtask

  // One instruction starting at a fetch-cycle negedge. scramble: R12 opcode noise.
  task automatic run_instr(logic [5:0] op, bit scramble);
    int seq[5];
    int n;
    string tag;
    opcode = op;
    case (op)
      6'b000000: begin seq = '{0,1,6,7,0}; n = 4; end  // R7: 4 cycles
      6'b000010: begin seq = '{0,1,9,0,0}; n = 3; end  // R9: 3 cycles
      6'b000100: begin seq = '{0,1,8,0,0}; n = 3; end  // R8: 3 cycles
      6'b100011: begin seq = '{0,1,2,3,4}; n = 5; end  // R5: 5 cycles
      6'b101011: begin seq = '{0,1,2,5,0}; n = 4; end  // R6: 4 cycles
      default:   begin seq = '{0,1,0,0,0}; n = 2; end  // R11
    endcase
    for (int i = 0; i < n; i++) begin
      tag = req_of(seq[i]);
      if (i == 0 && pend_ill) tag = "R11";
      if (scramble && seq[i] != 1 && seq[i] != 2) tag = {tag, "/R12"};
      check(seq[i], (i == 0) ? pend_ill : 1'b0, tag);
      if (scramble && i > 0 && seq[i] != 1 && seq[i] != 2) opcode = op ^ 6'h2A;
      else opcode = op;
      @(negedge clk);
    end
    pend_ill = (n == 2);
  endtask

  initial begin
    rst_n = 1'b0;
    opcode = 6'b000100;
    pend_ill = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      check(0, 1'b0, "R1 reset");
      @(negedge clk);
    end
    rst_n = 1'b1;
    // R1: two synchronizer stages keep fetch after release
    for (int i = 0; i < 2; i++) begin
      check(0, 1'b0, "R1 release");
      @(negedge clk);
    end
    for (int s = 0; s < 2; s++) begin
      for (int op = 0; op < 64; op++) begin
        run_instr(op[5:0], s == 1);
      end
    end
    check(0, pend_ill, "R11 final");
    @(negedge clk);
    check(1, 1'b0, "R2 final");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule